// File: doc/BRIEF.md
# Write Latency Training Sequencer

This block runs the second pass of DDR write training. It starts after the strobe has been aligned to the clock at each device, and it decides whether each byte lane's write path needs extra pipeline stages. For every rank it issues a training write at the shortest write-path pipeline and reads the data back. It then hands the readback to an external per-lane classifier, stores the stage adjustment the classifier returns, and checks that adjustment with a validation write and read.

Ranks are handled one after another in ascending order, and all byte lanes of a rank are handled together. Each lane keeps a warning bit, an error bit and an adjustment field for each rank. A single flag reports an error on any lane of any rank. A rank that fails still lets the sequence move on to the next rank. The outputs keep their values until the next start.

Top module: `wrlat_train_seq`

## Requirements
- R1: After reset, `busy`, `done`, `cmd_valid`, `cls_req`, `any_err` and all bits of `lane_err`, `lane_warn` and `lane_adj` are 0.
- R2: For each rank r, taken in ascending order from 0, the block first issues a write command with `cmd_min_depth`=1 and `cmd_rank`=r. It issues a read with the same rank and flag in the very next cycle, and no command in the cycle after that read.
- R3: Once training read data is accepted, `cls_req` stays high with `cls_rank` held steady until `cls_ack`. At `cls_ack` the rank's slots take `cls_adj` and `cls_warn`. Lane l of rank r uses bit r*LANES+l of the warn and error vectors and bits (r*LANES+l)*ADJ_W upward of `lane_adj`.
- R4: After the classifier answers, the block issues a validation write with `cmd_min_depth`=0 and the same rank. A read follows in the next cycle.
- R5: When validation data is accepted, the rank's error bit is set for each lane whose `rd_lane_ok` bit is 0. The adjustment keeps the classifier's value.
- R6: If `rd_valid` does not arrive within TIMEOUT (64) cycles of the first waiting cycle, every lane of that rank is flagged as an error and the block moves to the next rank. Data in the 64th waiting cycle is still accepted. A timeout on the training read skips classification and leaves warn and adjustment at 0.
- R7: `any_err` is the OR of all `lane_err` bits.
- R8: `done` is high for exactly one cycle after the last rank, and `busy` is 0 from the next cycle on. Status stays unchanged while idle and is cleared when a new start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a training run (taken when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_write | output | 1 | 1 write, 0 read |
| cmd_rank | output | RANK_W | Target rank |
| cmd_min_depth | output | 1 | 1: shortest write pipeline (training pass) |
| rd_valid | input | 1 | Readback captured |
| rd_lane_ok | input | LANES | Per-lane compare result for the validation read |
| cls_req | output | 1 | Request to the classifier |
| cls_rank | output | RANK_W | Rank being classified |
| cls_ack | input | 1 | Classifier result valid |
| cls_adj | input | LANES*ADJ_W | Per-lane stage adjustment |
| cls_warn | input | LANES | Per-lane mismatch warning |
| lane_adj | output | RANKS*LANES*ADJ_W | Stored adjustments |
| lane_warn | output | RANKS*LANES | Warning bits |
| lane_err | output | RANKS*LANES | Error bits |
| any_err | output | 1 | OR of all error bits |

## Verification
The checks assume that `start` is raised only while the block is idle and that `cls_ack` comes only while `cls_req` is high. They also assume that `rd_valid` pulses for one cycle per read and never outside the wait that follows a read. The bench works as the memory and the classifier. It answers each command only after it has seen that command, delays `rd_valid` by a chosen number of waiting cycles up to the last one that is still accepted, or leaves it out to cause a timeout. It always keeps `start` low during a run.

// File: rtl/wlt_pkg.sv
package wlt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WR_TRN, ST_RD_TRN, ST_WT_TRN, ST_CLASS,
    ST_WR_VAL, ST_RD_VAL, ST_WT_VAL, ST_NEXT, ST_DONE
  } wlt_state_e;

  // flat slot of a (rank, lane) pair in the status vectors
  function automatic int slot_idx(input int rank, input int lane, input int lanes);
    return rank * lanes + lane;
  endfunction
endpackage

// File: rtl/wlt_timer.sv
module wlt_timer #(
  parameter int LIMIT = 64,
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (cnt_q != CNT_W'(LIMIT - 1)) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/wlt_status.sv
module wlt_status #(
  parameter int RANKS  = 2,
  parameter int LANES  = 9,
  parameter int ADJ_W  = 2,
  parameter int RANK_W = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr_cls,
  input  logic                         wr_err,
  input  logic [RANK_W-1:0]            rank,
  input  logic [LANES*ADJ_W-1:0]       adj_in,
  input  logic [LANES-1:0]             warn_in,
  input  logic [LANES-1:0]             err_in,
  output logic [RANKS*LANES*ADJ_W-1:0] adj_q,
  output logic [RANKS*LANES-1:0]       warn_q,
  output logic [RANKS*LANES-1:0]       err_q
);
  import wlt_pkg::*;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    localparam int BASE = slot_idx(r, 0, LANES);
    logic sel;
    assign sel = (rank == RANK_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        adj_q[BASE*ADJ_W +: LANES*ADJ_W] <= '0;
        warn_q[BASE +: LANES]            <= '0;
        err_q[BASE +: LANES]             <= '0;
      end else if (clr) begin
        adj_q[BASE*ADJ_W +: LANES*ADJ_W] <= '0;
        warn_q[BASE +: LANES]            <= '0;
        err_q[BASE +: LANES]             <= '0;
      end else begin
        if (wr_cls && sel) begin
          adj_q[BASE*ADJ_W +: LANES*ADJ_W] <= adj_in;
          warn_q[BASE +: LANES]            <= warn_in;
        end
        if (wr_err && sel)
          err_q[BASE +: LANES] <= err_q[BASE +: LANES] | err_in;
      end
    end
  end
endmodule

// File: rtl/wrlat_train_seq.sv
module wrlat_train_seq #(
  parameter int RANKS   = 2,
  parameter int LANES   = 9,
  parameter int ADJ_W   = 2,
  parameter int TIMEOUT = 64,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  output logic                         cmd_valid,
  output logic                         cmd_write,
  output logic [RANK_W-1:0]            cmd_rank,
  output logic                         cmd_min_depth,
  input  logic                         rd_valid,
  input  logic [LANES-1:0]             rd_lane_ok,
  output logic                         cls_req,
  output logic [RANK_W-1:0]            cls_rank,
  input  logic                         cls_ack,
  input  logic [LANES*ADJ_W-1:0]       cls_adj,
  input  logic [LANES-1:0]             cls_warn,
  output logic [RANKS*LANES*ADJ_W-1:0] lane_adj,
  output logic [RANKS*LANES-1:0]       lane_warn,
  output logic [RANKS*LANES-1:0]       lane_err,
  output logic                         any_err
);
  import wlt_pkg::*;

  wlt_state_e        state_q, state_d;
  logic [RANK_W-1:0] rank_q;

  // named internal events
  logic waiting, tmr_expire, ev_accept, ev_tmo, ev_cls_done, ev_clear, last_rank;
  logic wr_err;
  logic [LANES-1:0] err_vec;

  assign waiting     = (state_q == ST_WT_TRN) || (state_q == ST_WT_VAL);
  assign ev_accept   = waiting && rd_valid;
  assign ev_tmo      = tmr_expire && !rd_valid;
  assign ev_cls_done = (state_q == ST_CLASS) && cls_ack;
  assign ev_clear    = (state_q == ST_IDLE) && start;
  assign last_rank   = (rank_q == RANK_W'(RANKS - 1));

  wlt_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(waiting), .expire(tmr_expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_WR_TRN;
      ST_WR_TRN: state_d = ST_RD_TRN;
      ST_RD_TRN: state_d = ST_WT_TRN;
      ST_WT_TRN: if (ev_accept) state_d = ST_CLASS;
                 else if (ev_tmo) state_d = ST_NEXT;
      ST_CLASS:  if (cls_ack) state_d = ST_WR_VAL;
      ST_WR_VAL: state_d = ST_RD_VAL;
      ST_RD_VAL: state_d = ST_WT_VAL;
      ST_WT_VAL: if (ev_accept || ev_tmo) state_d = ST_NEXT;
      ST_NEXT:   state_d = last_rank ? ST_DONE : ST_WR_TRN;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rank_q  <= '0;
    end else begin
      state_q <= state_d;
      if (ev_clear) rank_q <= '0;
      else if (state_q == ST_NEXT && !last_rank) rank_q <= rank_q + 1'b1;
    end
  end

  // error capture: timeout flags every lane, validation flags failing lanes
  assign wr_err  = ev_tmo || ((state_q == ST_WT_VAL) && ev_accept);
  assign err_vec = ev_tmo ? '1 : ~rd_lane_ok;

  wlt_status #(.RANKS(RANKS), .LANES(LANES), .ADJ_W(ADJ_W), .RANK_W(RANK_W)) u_status (
    .clk(clk), .rst_n(rst_n), .clr(ev_clear),
    .wr_cls(ev_cls_done), .wr_err(wr_err), .rank(rank_q),
    .adj_in(cls_adj), .warn_in(cls_warn), .err_in(err_vec),
    .adj_q(lane_adj), .warn_q(lane_warn), .err_q(lane_err)
  );

  assign cmd_valid     = (state_q == ST_WR_TRN) || (state_q == ST_RD_TRN) ||
                         (state_q == ST_WR_VAL) || (state_q == ST_RD_VAL);
  assign cmd_write     = (state_q == ST_WR_TRN) || (state_q == ST_WR_VAL);
  assign cmd_min_depth = (state_q == ST_WR_TRN) || (state_q == ST_RD_TRN);
  assign cmd_rank      = rank_q;
  assign cls_req       = (state_q == ST_CLASS);
  assign cls_rank      = rank_q;
  assign busy          = (state_q != ST_IDLE);
  assign done          = (state_q == ST_DONE);
  assign any_err       = |lane_err;
endmodule

// File: rtl/wlt_seq_chk.sv
module wlt_seq_chk #(
  parameter int RANK_W = 1,
  parameter int ERR_W  = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic              cmd_min_depth,
  input logic [RANK_W-1:0] cmd_rank,
  input logic              cls_req,
  input logic              cls_ack,
  input logic [RANK_W-1:0] cls_rank,
  input logic [ERR_W-1:0]  lane_err
);
  // R2
  first_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> cmd_valid && cmd_write && cmd_min_depth && cmd_rank == '0);

  // R4
  wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write |=> cmd_valid && !cmd_write &&
      cmd_rank == $past(cmd_rank) && cmd_min_depth == $past(cmd_min_depth));

  // R2
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write |=> !cmd_valid);

  // R3
  cls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cls_req && !cls_ack |=> cls_req && $stable(cls_rank));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(lane_err));
endmodule

bind wrlat_train_seq wlt_seq_chk #(.RANK_W(RANK_W), .ERR_W(RANKS*LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_min_depth(cmd_min_depth),
  .cmd_rank(cmd_rank), .cls_req(cls_req), .cls_ack(cls_ack), .cls_rank(cls_rank),
  .lane_err(lane_err)
);

// File: tb/wrlat_train_seq_test.sv
module wrlat_train_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int RANKS = 2, LANES = 9, ADJ_W = 2, TIMEOUT = 64;
  localparam int NS = RANKS * LANES;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, cmd_valid, cmd_write, cmd_min_depth, cls_req;
  logic [0:0] cmd_rank, cls_rank;
  logic rd_valid = 0, cls_ack = 0;
  logic [LANES-1:0] rd_lane_ok = '0, cls_warn = '0;
  logic [LANES*ADJ_W-1:0] cls_adj = '0;
  logic [NS*ADJ_W-1:0] lane_adj;
  logic [NS-1:0] lane_warn, lane_err;
  logic any_err;

  int errors = 0, checks = 0, cycles = 0;
  logic [NS-1:0] e_err, e_warn;
  logic [NS*ADJ_W-1:0] e_adj;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrlat_train_seq #(.RANKS(RANKS), .LANES(LANES), .ADJ_W(ADJ_W), .TIMEOUT(TIMEOUT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_rank(cmd_rank),
    .cmd_min_depth(cmd_min_depth), .rd_valid(rd_valid), .rd_lane_ok(rd_lane_ok),
    .cls_req(cls_req), .cls_rank(cls_rank), .cls_ack(cls_ack), .cls_adj(cls_adj),
    .cls_warn(cls_warn), .lane_adj(lane_adj), .lane_warn(lane_warn),
    .lane_err(lane_err), .any_err(any_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // bench-side pattern formulas
  function automatic int p_adj(int t, int r, int l); return (t + 2*r + l) % 4; endfunction
  function automatic bit p_warn(int t, int r, int l); return ((t + r + l) % 3) == 0; endfunction
  function automatic bit p_ok(int t, int r, int l);
    if (t == 4) return 1'b1;
    return ((t*5 + r*3 + l) % 4) != 0;
  endfunction

  // wait at negedges until cmd_valid or done
  task automatic wait_evt(output bit got_cmd);
    got_cmd = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cmd_valid) begin got_cmd = 1; return; end
      if (done) return;
    end
  endtask

  task automatic respond(input int dly, input logic [LANES-1:0] ok);
    repeat (dly + 1) @(negedge clk);
    rd_valid = 1; rd_lane_ok = ok;
    @(negedge clk);
    rd_valid = 0; rd_lane_ok = '0;
  endtask

  task automatic run_scn(input int t);
    int mode = t % 4;
    int dly  = (mode == 3) ? TIMEOUT - 1 : t % 5;
    bit got, saw_done;
    logic [LANES-1:0] okv, wv;
    logic [LANES*ADJ_W-1:0] av;
    e_err = '0; e_warn = '0; e_adj = '0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    // the first command is visible at this negedge
    got = cmd_valid;
    for (int r = 0; r < RANKS; r++) begin
      bit trn_to = (mode == 1) && (r == RANKS - 1);
      bit val_to = (mode == 2) && (r == 0);
      if (r > 0) wait_evt(got);
      if (r == 0) chk(lane_err == '0 && lane_adj == '0, "R8 clear on start", lane_err, 0);
      chk(got && cmd_write && cmd_min_depth && cmd_rank == r[0:0], "R2 training write",
          {cmd_write, cmd_min_depth, cmd_rank}, {2'b11, r[0:0]});
      @(negedge clk);
      chk(cmd_valid && !cmd_write && cmd_min_depth && cmd_rank == r[0:0], "R2 training read",
          {cmd_valid, cmd_write}, 2'b10);
      for (int l = 0; l < LANES; l++) begin
        okv[l] = p_ok(t, r, l); wv[l] = p_warn(t, r, l);
        av[l*ADJ_W +: ADJ_W] = ADJ_W'(p_adj(t, r, l));
      end
      if (trn_to) begin
        for (int l = 0; l < LANES; l++) e_err[r*LANES + l] = 1'b1;
        continue;
      end
      respond(dly, '0);
      got = 0;
      for (int i = 0; i < 100 && !got; i++) begin
        if (cls_req) got = 1; else @(negedge clk);
      end
      chk(got && cls_rank == r[0:0], "R3 classifier request", {got, cls_rank}, {1'b1, r[0:0]});
      repeat (t % 3) @(negedge clk);
      chk(cls_req == 1'b1, "R3 request held", cls_req, 1);
      cls_ack = 1; cls_adj = av; cls_warn = wv;
      @(negedge clk);
      cls_ack = 0; cls_adj = '0; cls_warn = '0;
      for (int l = 0; l < LANES; l++) begin
        e_warn[r*LANES + l] = wv[l];
        e_adj[(r*LANES + l)*ADJ_W +: ADJ_W] = av[l*ADJ_W +: ADJ_W];
        e_err[r*LANES + l] = val_to ? 1'b1 : !okv[l];
      end
      if (!cmd_valid) wait_evt(got);
      chk(cmd_valid && cmd_write && !cmd_min_depth && cmd_rank == r[0:0], "R4 validation write",
          {cmd_valid, cmd_write, cmd_min_depth}, 3'b110);
      @(negedge clk);
      chk(cmd_valid && !cmd_write && !cmd_min_depth, "R4 validation read",
          {cmd_valid, cmd_write}, 2'b10);
      if (!val_to) respond(dly, okv);
    end
    saw_done = done;
    for (int i = 0; i < 300 && !saw_done; i++) begin
      @(negedge clk); saw_done = done;
    end
    chk(saw_done, "R8 done seen", saw_done, 1);
    @(negedge clk);
    chk(!done && !busy, "R8 done one cycle", {done, busy}, 0);
    chk(lane_err == e_err, (mode == 0 || mode == 3) ? "R5 lane errors" : "R6 timeout errors",
        lane_err, e_err);
    chk(lane_warn == e_warn, "R3 warn bits", lane_warn, e_warn);
    chk(lane_adj == e_adj, "R5 adjust kept", lane_adj, e_adj);
    chk(any_err == (|e_err), "R7 global error", any_err, |e_err);
    repeat (5) @(negedge clk);
    chk(lane_err == e_err && lane_adj == e_adj, "R8 status held idle", lane_err, e_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !cmd_valid && !cls_req && !any_err, "R1 reset outputs",
        {busy, done, cmd_valid, cls_req, any_err}, 0);
    chk(lane_err == '0 && lane_warn == '0 && lane_adj == '0, "R1 reset status",
        {lane_err, lane_warn}, 0);
    for (int t = 0; t < 8; t++) run_scn(t);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule